// File: doc/BRIEF.md
# Row Hit Buffer With Counter

This block gathers the hit words that the pixels of one row put on the shared row bus while a token travels along that row. Each accepted word is 12 bits wide: a 9-bit cell address and a 3-bit sample. On every token clock edge a valid word enters the front stage of a shift chain, and every word already held moves one stage deeper. At the end of a pass the oldest hit therefore sits deepest in the chain and the newest sits at the front. Cycles with no valid word leave the chain as it is.

A counter tracks how many words the pass has accepted. When the token comes back from the far end of the row, the pass closes. The count then stays frozen and later bus words are ignored until a clear starts the next pass. The chain depth is a parameter that is chosen to suit the expected hit density, for example 18 stages for a quiet background or 30 for a busy one. When the chain is full, further hits are discarded and a sticky overflow flag is raised. A downstream readout state machine reads the stored words by index through a combinational port.

Top module: `row_hit_buffer`

## Requirements
- R1: After reset, hit_cnt is 0, ovf is 0, tok_seen is 0 and every stored entry reads back as address 0, data 0.
- R2: A word with bus_vld high on an open pass, with the chain not full and clr low, is captured at the token clock edge into index 0. Every earlier entry moves from index k to index k+1 at that same edge.
- R3: After a pass, index hit_cnt-1 holds the earliest accepted word and index 0 holds the latest.
- R4: A cycle with bus_vld low leaves all stored entries and hit_cnt unchanged.
- R5: hit_cnt increases by one at each edge that captures a word and never exceeds DEPTH.
- R6: tok_ret high on an open pass sets tok_seen from the next edge. A valid word in that same cycle is still captured. After that, bus words change neither the entries nor hit_cnt until clr.
- R7: A valid word on an open pass with hit_cnt equal to DEPTH is discarded, the entries stay unchanged, and ovf becomes 1. ovf then stays 1 until clr.
- R8: clr high at an edge sets hit_cnt to 0, ovf to 0 and tok_seen to 0, and zeroes all entries. It takes priority over bus_vld and tok_ret in the same cycle.
- R9: rd_addr and rd_data show the entry at index rd_idx in the same cycle. rd_hit is 1 exactly when rd_idx is less than hit_cnt. An rd_idx of DEPTH or more reads as zeros with rd_hit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tok_clk | input | 1 | Token clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_vld | input | 1 | Row bus carries a hit word this cycle |
| bus_addr | input | 9 | Cell address on the row bus |
| bus_data | input | 3 | Sample value on the row bus |
| tok_ret | input | 1 | Token has come back from the end of the row |
| clr | input | 1 | Synchronous clear that starts a new pass |
| rd_idx | input | IDX_W (5) | Read index, 0 for the newest entry |
| rd_addr | output | 9 | Address field of the selected entry |
| rd_data | output | 3 | Sample field of the selected entry |
| rd_hit | output | 1 | Selected index holds a hit of this pass |
| hit_cnt | output | CNT_W (5) | Number of words accepted in this pass |
| ovf | output | 1 | Sticky flag: a hit was lost to a full chain |
| tok_seen | output | 1 | Token return has closed the pass |

## Verification
hit_cnt, ovf, tok_seen and the stored entries are registered. Each one reflects a bus, token-return or clear input one token clock after that input is driven. The read port is combinational, so a new rd_idx gives its result in the same cycle. The bench changes every input on the falling edge and updates its model at the rising edge. It compares all outputs, including a random read index, 1 ns after that rising edge. Full contents are scanned over idle cycles, during which the closed or idle state guarantees that nothing moves.

// File: rtl/rhb_pkg.sv
package rhb_pkg;
  localparam int ADDR_W = 9;
  localparam int DATA_W = 3;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } hit_word_t;

  typedef enum logic {
    PASS_OPEN   = 1'b0,
    PASS_CLOSED = 1'b1
  } pass_state_e;
endpackage

// File: rtl/rhb_rst_sync.sv
module rhb_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= '0;
    else           sync_q <= sync_d;
  end

  assign rst_n_out = sync_q[STAGES-1];
endmodule

// File: rtl/rhb_pass_ctrl.sv
module rhb_pass_ctrl
  import rhb_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic tok_ret,
  input  logic bus_vld,
  input  logic full,
  output logic pass_open,
  output logic accept,
  output logic drop
);
  pass_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (clr)                                state_d = PASS_OPEN;
    else if (state_q == PASS_OPEN && tok_ret) state_d = PASS_CLOSED;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= PASS_OPEN;
    else        state_q <= state_d;
  end

  assign pass_open = (state_q == PASS_OPEN);
  assign accept    = pass_open && bus_vld && !full && !clr;
  assign drop      = pass_open && bus_vld &&  full && !clr;

  // R6: token return closes the pass at the next edge
  a_r6_close: assert property (@(posedge clk) disable iff (!rst_n)
    (pass_open && tok_ret && !clr) |=> !pass_open);
  // R8: clear reopens the pass
  a_r8_reopen: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> pass_open);
endmodule

// File: rtl/rhb_hit_counter.sv
module rhb_hit_counter #(
  parameter int DEPTH = 18,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             accept,
  input  logic             drop,
  output logic [CNT_W-1:0] cnt,
  output logic             full,
  output logic             ovf
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             ovf_q, ovf_d;
  logic             cnt_en;

  assign cnt_en = clr || accept;

  always_comb begin
    cnt_d = cnt_q;
    if (clr)         cnt_d = '0;
    else if (accept) cnt_d = cnt_q + CNT_W'(1);
  end

  always_comb begin
    ovf_d = ovf_q;
    if (clr)       ovf_d = 1'b0;
    else if (drop) ovf_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ovf_q <= 1'b0;
    else        ovf_q <= ovf_d;
  end

  assign cnt  = cnt_q;
  assign full = (cnt_q == CNT_W'(DEPTH));
  assign ovf  = ovf_q;

  // R5: one step per captured word
  a_r5_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> cnt == $past(cnt) + CNT_W'(1));
  // R5: bounded by the depth
  a_r5_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(DEPTH));
  // R7: flag is sticky until clear
  a_r7_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !clr) |=> ovf);
  // R7: a dropped word leaves the count unchanged
  a_r7_drop_hold: assert property (@(posedge clk) disable iff (!rst_n)
    drop |=> (ovf && $stable(cnt)));
  // R8: clear empties the counter
  a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt == '0 && !ovf));
endmodule

// File: rtl/rhb_shift_chain.sv
module rhb_shift_chain
  import rhb_pkg::*;
#(
  parameter int DEPTH = 18
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  clr,
  input  logic                  shift_en,
  input  hit_word_t             din,
  output hit_word_t [DEPTH-1:0] stage_o
);
  hit_word_t [DEPTH-1:0] stage_q;
  hit_word_t [DEPTH-1:0] stage_d;
  logic                  stage_en;

  assign stage_en = clr || shift_en;

  for (genvar k = 0; k < DEPTH; k++) begin : g_stage
    if (k == 0) begin : g_head
      always_comb begin
        if (clr) stage_d[k] = '0;
        else     stage_d[k] = din;
      end
    end else begin : g_body
      always_comb begin
        if (clr) stage_d[k] = '0;
        else     stage_d[k] = stage_q[k-1];
      end
      // R2: every entry moves one index deeper on a capture
      a_r2_shift: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> stage_o[k] == $past(stage_o[k-1]));
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        stage_q[k] <= '0;
      else if (stage_en) stage_q[k] <= stage_d[k];
    end

    // R4: entries hold when nothing is captured
    a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!shift_en && !clr) |=> $stable(stage_o[k]));
  end

  assign stage_o = stage_q;

  // R2: captured word lands at the front
  a_r2_head: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> stage_o[0] == $past(din));
endmodule

// File: rtl/rhb_read_mux.sv
module rhb_read_mux
  import rhb_pkg::*;
#(
  parameter int DEPTH = 18,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  hit_word_t [DEPTH-1:0] stage_i,
  input  logic [CNT_W-1:0]      cnt,
  input  logic [IDX_W-1:0]      idx,
  output hit_word_t             word_o,
  output logic                  hit_o
);
  always_comb begin
    word_o = '0;
    for (int k = 0; k < DEPTH; k++) begin
      if (int'(idx) == k) word_o = stage_i[k];
    end
  end

  assign hit_o = (int'(idx) < int'(cnt));

  // R9: an index past the depth never reports a hit
  always_comb begin
    if (int'(idx) >= DEPTH) a_r9_oob: assert (!hit_o && word_o == '0);
  end
endmodule

// File: rtl/row_hit_buffer.sv
module row_hit_buffer
  import rhb_pkg::*;
#(
  parameter int DEPTH = 18,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              tok_clk,
  input  logic              rst_n,
  input  logic              bus_vld,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_data,
  input  logic              tok_ret,
  input  logic              clr,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_hit,
  output logic [CNT_W-1:0]  hit_cnt,
  output logic              ovf,
  output logic              tok_seen
);
  logic                  rst_n_s;
  logic                  pass_open;
  logic                  accept;
  logic                  drop;
  logic                  full;
  hit_word_t             bus_word;
  hit_word_t             rd_word;
  hit_word_t [DEPTH-1:0] stages;

  assign bus_word.addr = bus_addr;
  assign bus_word.data = bus_data;

  rhb_rst_sync #(.STAGES(2)) i_rst_sync (
    .clk       (tok_clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_n_s)
  );

  rhb_pass_ctrl i_pass_ctrl (
    .clk       (tok_clk),
    .rst_n     (rst_n_s),
    .clr       (clr),
    .tok_ret   (tok_ret),
    .bus_vld   (bus_vld),
    .full      (full),
    .pass_open (pass_open),
    .accept    (accept),
    .drop      (drop)
  );

  rhb_hit_counter #(.DEPTH(DEPTH)) i_counter (
    .clk    (tok_clk),
    .rst_n  (rst_n_s),
    .clr    (clr),
    .accept (accept),
    .drop   (drop),
    .cnt    (hit_cnt),
    .full   (full),
    .ovf    (ovf)
  );

  rhb_shift_chain #(.DEPTH(DEPTH)) i_chain (
    .clk      (tok_clk),
    .rst_n    (rst_n_s),
    .clr      (clr),
    .shift_en (accept),
    .din      (bus_word),
    .stage_o  (stages)
  );

  rhb_read_mux #(.DEPTH(DEPTH)) i_read (
    .stage_i (stages),
    .cnt     (hit_cnt),
    .idx     (rd_idx),
    .word_o  (rd_word),
    .hit_o   (rd_hit)
  );

  assign rd_addr  = rd_word.addr;
  assign rd_data  = rd_word.data;
  assign tok_seen = !pass_open;

  // R6: a closed pass keeps its count until clear
  a_r6_frozen: assert property (@(posedge tok_clk) disable iff (!rst_n_s)
    (tok_seen && !clr) |=> $stable(hit_cnt));
  // R4: idle bus leaves the count alone
  a_r4_idle_cnt: assert property (@(posedge tok_clk) disable iff (!rst_n_s)
    (!bus_vld && !clr) |=> $stable(hit_cnt));
endmodule

// File: tb/test_row_hit_buffer.sv
`timescale 1ns/1ps
module test_row_hit_buffer;
  localparam int DEPTH = 18;
  localparam int IDX_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic             tok_clk = 1'b0;
  logic             rst_n;
  logic             bus_vld;
  logic [8:0]       bus_addr;
  logic [2:0]       bus_data;
  logic             tok_ret;
  logic             clr;
  logic [IDX_W-1:0] rd_idx;
  logic [8:0]       rd_addr;
  logic [2:0]       rd_data;
  logic             rd_hit;
  logic [CNT_W-1:0] hit_cnt;
  logic             ovf;
  logic             tok_seen;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  logic [11:0] mdl [DEPTH];
  int          m_cnt;
  bit          m_ovf;
  bit          m_open;

  always #2.5 tok_clk = ~tok_clk;

  row_hit_buffer #(.DEPTH(DEPTH)) i_row_hit_buffer (
    .tok_clk, .rst_n, .bus_vld, .bus_addr, .bus_data, .tok_ret, .clr,
    .rd_idx, .rd_addr, .rd_data, .rd_hit, .hit_cnt, .ovf, .tok_seen
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [11:0] exp_word(input int idx);
    if (idx < DEPTH) return mdl[idx];
    return 12'h000;
  endfunction

  function automatic bit exp_hit(input int idx);
    return idx < m_cnt;
  endfunction

  task automatic model_clear();
    for (int k = 0; k < DEPTH; k++) mdl[k] = '0;
    m_cnt = 0; m_ovf = 0; m_open = 1;
  endtask

  task automatic model_edge(input bit v, input logic [11:0] w, input bit tr, input bit c);
    if (c) begin
      model_clear();
    end else begin
      if (m_open && v) begin
        if (m_cnt < DEPTH) begin
          for (int k = DEPTH-1; k > 0; k--) mdl[k] = mdl[k-1];
          mdl[0] = w;
          m_cnt++;
        end else begin
          m_ovf = 1;
        end
      end
      if (m_open && tr) m_open = 0;
    end
  endtask

  task automatic check_outputs(input string tag);
    chk({tag, " R5 hit_cnt"}, int'(hit_cnt), m_cnt);
    chk({tag, " R7 ovf"}, int'(ovf), int'(m_ovf));
    chk({tag, " R6 tok_seen"}, int'(tok_seen), int'(!m_open));
    chk({tag, " R9 rd_hit"}, int'(rd_hit), int'(exp_hit(int'(rd_idx))));
    chk({tag, " R2 rd_word"}, int'({rd_addr, rd_data}), int'(exp_word(int'(rd_idx))));
  endtask

  task automatic step(input bit v, input logic [11:0] w, input bit tr, input bit c,
                      input int idx, input string tag);
    @(negedge tok_clk);
    bus_vld = v; {bus_addr, bus_data} = w; tok_ret = tr; clr = c;
    rd_idx = IDX_W'(idx);
    @(posedge tok_clk);
    model_edge(v, w, tr, c);
    #1;
    check_outputs(tag);
  endtask

  task automatic scan(input string tag);
    for (int i = 0; i < (1 << IDX_W); i++) step(0, 12'h000, 0, 0, i, tag);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int unused_seed;
    unused_seed = $urandom(32'd20461);
    rst_n = 0; bus_vld = 0; bus_addr = '0; bus_data = '0;
    tok_ret = 0; clr = 0; rd_idx = '0;
    model_clear();
    repeat (3) @(posedge tok_clk);
    @(negedge tok_clk) rst_n = 1;
    repeat (3) @(posedge tok_clk);

    // R1: reset state over all indices
    scan("R1 reset");

    // R2 R3 R4: five words with idle gaps, last one together with token return (R6)
    step(1, 12'h101, 0, 0, 0, "R2 first");
    step(0, 12'hFFF, 0, 0, 0, "R4 gap");
    step(1, 12'h222, 0, 0, 1, "R2 second");
    step(1, 12'h343, 0, 0, 1, "R2 third");
    step(0, 12'hABC, 0, 0, 2, "R4 gap");
    step(1, 12'h454, 0, 0, 3, "R2 fourth");
    step(1, 12'h565, 1, 0, 4, "R6 word with return");
    chk("R3 count after pass", int'(hit_cnt), 5);
    scan("R3 order");
    // R6: words after return are ignored
    step(1, 12'h777, 0, 0, 0, "R6 ignored");
    step(1, 12'h778, 1, 0, 5, "R6 ignored");
    scan("R6 frozen");

    // R8: clear with a valid word and token return in the same cycle
    step(1, 12'h999, 1, 1, 0, "R8 clear priority");
    chk("R8 tok_seen after clear", int'(tok_seen), 0);
    scan("R8 empty");

    // R7: overflow with DEPTH+3 words
    for (int i = 0; i < DEPTH + 3; i++)
      step(1, 12'(i * 37 + 5), 0, 0, i % (1 << IDX_W), "R7 fill");
    chk("R7 ovf set", int'(ovf), 1);
    scan("R7 contents");
    step(0, 12'h0, 1, 0, 0, "R7 close");
    step(0, 12'h0, 0, 0, 0, "R7 sticky");
    step(0, 12'h0, 0, 1, 0, "R8 clear ovf");

    // random passes
    for (int p = 0; p < 60; p++) begin
      int len = 1 + int'($urandom_range(0, 30));
      int prob = int'($urandom_range(10, 90));
      for (int c = 0; c < len; c++) begin
        bit v = ($urandom_range(0, 99) < prob);
        bit tr = (c == len - 1) || ($urandom_range(0, 99) < 3);
        bit cl = ($urandom_range(0, 199) == 0);
        step(v, 12'($urandom), tr, cl, int'($urandom_range(0, (1 << IDX_W) - 1)), "R2 random");
      end
      repeat (2) step(1, 12'($urandom), 0, 0, int'($urandom_range(0, DEPTH-1)), "R6 random after");
      if (p % 6 == 0) scan("R3 random scan");
      step(0, 12'h0, 0, 1, 0, "R8 random clear");
    end

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule